// File: doc/BRIEF.md
# Start-of-Transmission Plateau Monitor

This block sits on the receive side of a serial display lane. It watches the lane's low-power line levels and an indicator of high-speed activity, both sampled on a fast clock. From these it decides whether each entry into high-speed mode went through the full entry sequence: idle-high (both lines 1), then Dp low (Dp=0, Dn=1), then both low, then high-speed activity. It also measures how long the two low states lasted. A receiver cannot see a low plateau that is too short. A lane that jumps straight from idle-high into high-speed activity gives the receiver no entry sequence at all. The monitor reports these two cases separately, so a flicker-prone link can be caught in the field.

The monitor counts duration in sample-clock cycles. Each reported entry gives the total plateau length and the part of it spent with both lines low. A one-cycle pulse classifies the entry as good, short or absent. A separate pulse marks an out-of-order line state that aborts the measurement. On a link whose clock lane stays in continuous high-speed mode, a failed entry is never retried. Any failure therefore sets a flag that only a reset clears. Three event counters keep totals until a clear input zeroes them.

Top module: `sot_plateau_mon`

## Requirements
- R1: The line pair is read as {lp_dp, lp_dn}: 2'b11 idle-high, 2'b01 entry-low, 2'b00 both-low, 2'b10 illegal during entry. The sequence 11, 01 (one or more cycles), 00 (one or more cycles), then hs_active=1 with a plateau at or above threshold gives a one-cycle sot_ok in the cycle after hs_active is first sampled high.
- R2: When a good or short entry is reported, plateau_len equals the number of sampled 01 cycles plus 00 cycles, and exit_to_hs equals the number of sampled 00 cycles. Both hold their values until the next report.
- R3: A plateau strictly below the threshold gives sot_short instead of sot_ok. A plateau equal to the threshold is good.
- R4: hs_active sampled high while armed in idle-high, with no low state seen, gives sot_missing and reports plateau_len = exit_to_hs = 0.
- R5: An out-of-order state during entry aborts the measurement, gives a one-cycle seq_err, changes no event counter and leaves the reported lengths unchanged. The out-of-order states are 10 at any point, 00 straight after 11, a return to 11 from 01 or 00, and hs_active during 01.
- R6: An idle-high period of any length produces no pulse, and a normal entry after it is judged as usual.
- R7: fail_latched is 0 after reset. It sets with the first sot_short or sot_missing and stays set through later good entries until reset.
- R8: The threshold resets to 10 sample cycles. A cycle with thr_load=1 loads thr_value, which applies to entries judged afterwards.
- R9: Duration counts saturate at all ones (4095 for the default 12-bit width) and do not wrap.
- R10: ok_count, short_count and missing_count (16 bits) each increase by one with their pulse. cnt_clr zeroes all three and wins over a same-cycle increment.
- R11: At most one of sot_ok, sot_short, sot_missing and seq_err is high in any cycle. After high-speed activity, a new entry is accepted only after the line returns to 11 with hs_active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset, ends the session |
| lp_dp | input | 1 | Decoded low-power level of the positive line |
| lp_dn | input | 1 | Decoded low-power level of the negative line |
| hs_active | input | 1 | High-speed activity detected on the lane |
| thr_load | input | 1 | Load thr_value into the threshold register |
| thr_value | input | CNT_W | New minimum plateau in sample cycles |
| cnt_clr | input | 1 | Clear the three event counters |
| plateau_len | output | CNT_W | Last reported 01 plus 00 duration |
| exit_to_hs | output | CNT_W | Last reported 00 duration before high speed |
| sot_ok | output | 1 | Pulse: complete entry with adequate plateau |
| sot_short | output | 1 | Pulse: plateau present but below threshold |
| sot_missing | output | 1 | Pulse: direct jump from idle-high to high speed |
| seq_err | output | 1 | Pulse: out-of-order state aborted the entry |
| fail_latched | output | 1 | Sticky failure flag for the session |
| ok_count | output | EVT_W | Good entries since clear |
| short_count | output | EVT_W | Short entries since clear |
| missing_count | output | EVT_W | Absent entries since clear |

## Verification
The assertions check, on every cycle, the properties that hold whatever the stimulus. The four pulses never overlap. A short or good verdict agrees with the threshold held at the deciding edge. An absent entry reports zero lengths, and the both-low part never exceeds the total plateau. The failure flag is sticky and rises only with a failure pulse. The counters step by one or clear, and a sequence error leaves them unchanged. The bench scenarios show what a property cannot: the exact cycle counts of measured plateaus, the boundary at the threshold and at a reloaded threshold, saturation after several thousand cycles, silence through a long idle, re-arming only through idle-high, and the clear winning over a same-cycle event.

// File: rtl/sot_plateau_mon.sv
module sot_plateau_mon #(
  parameter int CNT_W        = 12,
  parameter int EVT_W        = 16,
  parameter int MIN_PLAT_DEF = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_dp,
  input  logic             lp_dn,
  input  logic             hs_active,
  input  logic             thr_load,
  input  logic [CNT_W-1:0] thr_value,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] plateau_len,
  output logic [CNT_W-1:0] exit_to_hs,
  output logic             sot_ok,
  output logic             sot_short,
  output logic             sot_missing,
  output logic             seq_err,
  output logic             fail_latched,
  output logic [EVT_W-1:0] ok_count,
  output logic [EVT_W-1:0] short_count,
  output logic [EVT_W-1:0] missing_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [EVT_W-1:0] EVT_MAX = '1;

  typedef enum logic [2:0] {S_WAIT, S_ARMED, S_LP01, S_LP00, S_HS} st_t;

  st_t st, st_nxt;
  logic [CNT_W-1:0] plat_q, ex_q, thr_q;

  wire [1:0] ln   = {lp_dp, lp_dn};
  wire is11 = (ln == 2'b11);
  wire is01 = (ln == 2'b01);
  wire is00 = (ln == 2'b00);

  wire low_ok   = !hs_active && (is01 || is00);
  wire judge    = (st == S_LP00) && hs_active;
  wire ev_ok    = judge && (plat_q >= thr_q);
  wire ev_short = judge && (plat_q < thr_q);
  wire ev_miss  = (st == S_ARMED) && hs_active;
  wire ev_seq   = ((st == S_ARMED) && !hs_active && !is11 && !is01) ||
                  ((st == S_LP01) && !low_ok) ||
                  ((st == S_LP00) && !hs_active && !is00);

  wire [CNT_W-1:0] plat_inc = (plat_q == CNT_MAX) ? plat_q : plat_q + 1'b1;
  wire [CNT_W-1:0] ex_inc   = (ex_q == CNT_MAX) ? ex_q : ex_q + 1'b1;

  always_comb begin
    st_nxt = st;
    case (st)
      S_WAIT:  if (!hs_active && is11) st_nxt = S_ARMED;
      S_ARMED: if (hs_active)          st_nxt = S_HS;
               else if (is01)          st_nxt = S_LP01;
               else if (!is11)         st_nxt = S_WAIT;
      S_LP01:  if (!low_ok)            st_nxt = S_WAIT;
               else if (is00)          st_nxt = S_LP00;
      S_LP00:  if (hs_active)          st_nxt = S_HS;
               else if (!is00)         st_nxt = S_WAIT;
      S_HS:    if (!hs_active && is11) st_nxt = S_ARMED;
      default:                         st_nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      plat_q <= '0;
      ex_q   <= '0;
    end else begin
      st <= st_nxt;
      if (st == S_ARMED && !hs_active && is01) begin
        plat_q <= CNT_W'(1);
        ex_q   <= '0;
      end else if ((st == S_LP01 || st == S_LP00) && low_ok) begin
        plat_q <= plat_inc;
        if (is00) ex_q <= (st == S_LP01) ? CNT_W'(1) : ex_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q        <= CNT_W'(MIN_PLAT_DEF);
      plateau_len  <= '0;
      exit_to_hs   <= '0;
      sot_ok       <= 1'b0;
      sot_short    <= 1'b0;
      sot_missing  <= 1'b0;
      seq_err      <= 1'b0;
      fail_latched <= 1'b0;
    end else begin
      if (thr_load) thr_q <= thr_value;
      if (judge) begin
        plateau_len <= plat_q;
        exit_to_hs  <= ex_q;
      end else if (ev_miss) begin
        plateau_len <= '0;
        exit_to_hs  <= '0;
      end
      sot_ok       <= ev_ok;
      sot_short    <= ev_short;
      sot_missing  <= ev_miss;
      seq_err      <= ev_seq;
      fail_latched <= fail_latched | ev_short | ev_miss;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_count      <= '0;
      short_count   <= '0;
      missing_count <= '0;
    end else if (cnt_clr) begin
      ok_count      <= '0;
      short_count   <= '0;
      missing_count <= '0;
    end else begin
      if (ev_ok && ok_count != EVT_MAX)            ok_count      <= ok_count + 1'b1;
      if (ev_short && short_count != EVT_MAX)      short_count   <= short_count + 1'b1;
      if (ev_miss && missing_count != EVT_MAX)     missing_count <= missing_count + 1'b1;
    end
  end
endmodule

// File: rtl/sot_plateau_mon_chk.sv
module sot_plateau_mon_chk #(
  parameter int CNT_W = 12,
  parameter int EVT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] thr,
  input logic [CNT_W-1:0] plateau_len,
  input logic [CNT_W-1:0] exit_to_hs,
  input logic             sot_ok,
  input logic             sot_short,
  input logic             sot_missing,
  input logic             seq_err,
  input logic             fail_latched,
  input logic [EVT_W-1:0] ok_count,
  input logic [EVT_W-1:0] short_count,
  input logic [EVT_W-1:0] missing_count
);
  localparam logic [EVT_W-1:0] EVT_MAX = '1;

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sot_ok, sot_short, sot_missing, seq_err}));

  // R1
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sot_ok |=> !sot_ok);

  // R3
  short_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sot_short |-> plateau_len < $past(thr));

  // R3
  ok_at_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sot_ok |-> (plateau_len >= $past(thr)) && (exit_to_hs != '0));

  // R4
  missing_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sot_missing |-> (plateau_len == '0) && (exit_to_hs == '0));

  // R2
  exit_within_plateau_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_to_hs <= plateau_len);

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_latched |=> fail_latched);

  // R7
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_latched) |-> (sot_short || sot_missing));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (ok_count == '0) && (short_count == '0) && (missing_count == '0));

  // R10
  ok_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_ok && !$past(cnt_clr) && $past(ok_count) != EVT_MAX) |->
      ok_count == $past(ok_count) + 1'b1);

  // R10
  short_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_short && !$past(cnt_clr) && $past(short_count) != EVT_MAX) |->
      short_count == $past(short_count) + 1'b1);

  // R5
  seq_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !$past(cnt_clr)) |->
      $stable(ok_count) && $stable(short_count) && $stable(missing_count) && $stable(plateau_len));
endmodule

bind sot_plateau_mon sot_plateau_mon_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .thr(thr_q),
  .plateau_len(plateau_len), .exit_to_hs(exit_to_hs),
  .sot_ok(sot_ok), .sot_short(sot_short), .sot_missing(sot_missing),
  .seq_err(seq_err), .fail_latched(fail_latched),
  .ok_count(ok_count), .short_count(short_count), .missing_count(missing_count)
);

// File: tb/tb_sot_plateau_mon.sv
module tb_sot_plateau_mon;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int EW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp = 1'b1, dn = 1'b1, hs = 1'b0, thr_load = 1'b0, cnt_clr = 1'b0;
  logic [CW-1:0] thr_value = '0;
  logic [CW-1:0] plateau_len, exit_to_hs;
  logic sot_ok, sot_short, sot_missing, seq_err, fail_latched;
  logic [EW-1:0] ok_count, short_count, missing_count;

  int checks = 0, errors = 0;
  int e_ok = 0, e_sh = 0, e_mi = 0;

  sot_plateau_mon dut (
    .clk(clk), .rst_n(rst_n), .lp_dp(dp), .lp_dn(dn), .hs_active(hs),
    .thr_load(thr_load), .thr_value(thr_value), .cnt_clr(cnt_clr),
    .plateau_len(plateau_len), .exit_to_hs(exit_to_hs),
    .sot_ok(sot_ok), .sot_short(sot_short), .sot_missing(sot_missing),
    .seq_err(seq_err), .fail_latched(fail_latched),
    .ok_count(ok_count), .short_count(short_count), .missing_count(missing_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] ln, input logic h, input int n);
    repeat (n) begin
      @(negedge clk);
      {dp, dn} = ln;
      hs = h;
    end
  endtask

  function automatic int pulses();
    return int'({sot_ok, sot_short, sot_missing, seq_err});
  endfunction

  task automatic expect_evt(input string tag, input int ok, input int sh, input int mi,
                            input int pl, input int ex);
    @(negedge clk);
    chk(tag, "pulses {ok,short,missing,seq}", pulses(), ok*8 + sh*4 + mi*2);
    chk(tag, "plateau_len", int'(plateau_len), pl);
    chk(tag, "exit_to_hs", int'(exit_to_hs), ex);
    e_ok += ok; e_sh += sh; e_mi += mi;
    chk("R10", "counts", int'(ok_count)*1000000 + int'(short_count)*1000 + int'(missing_count),
        e_ok*1000000 + e_sh*1000 + e_mi);
    @(negedge clk);
    chk("R11", "pulse width one cycle", pulses(), 0);
  endtask

  task automatic sot(input string tag, input int n01, input int n00, input int good);
    hold(2'b11, 1'b0, 2);
    hold(2'b01, 1'b0, n01);
    hold(2'b00, 1'b0, n00);
    hold(2'b00, 1'b1, 1);
    expect_evt(tag, good, 1 - good, 0, (n01 + n00 > 4095) ? 4095 : n01 + n00,
               (n00 > 4095) ? 4095 : n00);
  endtask

  task automatic expect_seq(input string tag, input int pl);
    @(negedge clk);
    chk(tag, "seq_err pulse only", pulses(), 1);
    chk(tag, "lengths kept", int'(plateau_len), pl);
    chk(tag, "counts kept", int'(ok_count)*1000000 + int'(short_count)*1000 + int'(missing_count),
        e_ok*1000000 + e_sh*1000 + e_mi);
  endtask

  task automatic t_reset();
    chk("R7", "fail_latched after reset", int'(fail_latched), 0);
    chk("R10", "counts after reset", int'(ok_count) + int'(short_count) + int'(missing_count), 0);
    chk("R11", "no pulse after reset", pulses(), 0);
    chk("R2", "lengths after reset", int'(plateau_len) + int'(exit_to_hs), 0);
  endtask

  task automatic t_good();
    sot("R1", 4, 8, 1);
    sot("R2", 1, 20, 1);
    chk("R7", "no failure after good entries", int'(fail_latched), 0);
  endtask

  task automatic t_boundary();
    sot("R3", 3, 7, 1);
    sot("R3", 3, 6, 0);
    chk("R7", "set by short", int'(fail_latched), 1);
    sot("R7", 2, 12, 1);
    chk("R7", "still set after good", int'(fail_latched), 1);
  endtask

  task automatic t_missing();
    hold(2'b11, 1'b0, 2);
    hold(2'b11, 1'b1, 1);
    expect_evt("R4", 0, 0, 1, 0, 0);
  endtask

  task automatic t_seq();
    sot("R5", 5, 6, 1);
    hold(2'b11, 1'b0, 2); hold(2'b01, 1'b0, 2); hold(2'b10, 1'b0, 1);
    expect_seq("R5", 11);
    hold(2'b11, 1'b0, 2); hold(2'b00, 1'b0, 1);
    expect_seq("R5", 11);
    hold(2'b11, 1'b0, 2); hold(2'b01, 1'b0, 3); hold(2'b11, 1'b1, 1);
    expect_seq("R5", 11);
    hold(2'b11, 1'b0, 2); hold(2'b01, 1'b0, 2); hold(2'b00, 1'b0, 2); hold(2'b11, 1'b0, 1);
    expect_seq("R5", 11);
    sot("R5", 2, 9, 1);
  endtask

  task automatic t_idle();
    int bad = 0;
    hold(2'b11, 1'b0, 1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pulses() != 0) bad++;
    end
    chk("R6", "pulses during long idle", bad, 0);
    sot("R6", 2, 10, 1);
  endtask

  task automatic t_rearm();
    int bad = 0;
    hold(2'b01, 1'b0, 3); hold(2'b00, 1'b0, 3); hold(2'b00, 1'b1, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (pulses() != 0) bad++;
    end
    chk("R11", "no entry without idle-high", bad, 0);
    sot("R11", 3, 9, 1);
  endtask

  task automatic t_thr();
    @(negedge clk); thr_load = 1'b1; thr_value = 12'd20;
    @(negedge clk); thr_load = 1'b0;
    sot("R8", 5, 14, 0);
    sot("R8", 5, 15, 1);
    @(negedge clk); thr_load = 1'b1; thr_value = 12'd10;
    @(negedge clk); thr_load = 1'b0;
    sot("R8", 1, 9, 1);
  endtask

  task automatic t_sat();
    sot("R9", 4100, 3, 1);
    sot("R9", 1, 4200, 1);
  endtask

  task automatic t_clear();
    hold(2'b11, 1'b0, 2); hold(2'b01, 1'b0, 3); hold(2'b00, 1'b0, 8);
    @(negedge clk); hs = 1'b1; cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk("R10", "event seen with clear", int'(sot_ok), 1);
    chk("R10", "clear wins", int'(ok_count) + int'(short_count) + int'(missing_count), 0);
    e_ok = 0; e_sh = 0; e_mi = 0;
    sot("R10", 2, 3, 0);
  endtask

  task automatic t_reset_latch();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R7", "cleared by reset", int'(fail_latched), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_good();
    t_boundary();
    t_missing();
    t_seq();
    t_idle();
    t_rearm();
    t_thr();
    t_sat();
    t_clear();
    t_reset_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule